// File: doc/BRIEF.md
# Boot Source Selection Sequencer

After reset this block decides where execution begins. It first watches the two serial bus lines (SDA, SCL) for a fixed identification pattern. If the pattern appears, it selects download mode, in which code is loaded into internal RAM and run from there. If the pattern is absent, it reads a two-byte signature from external memory at FFD6h/FFD7h. The value A55Ah selects the external application; any other value selects the internal application.

The memory side is a byte port with a request/acknowledge handshake. A read that is not acknowledged within a bounded wait counts as a signature mismatch. The result is a 2-bit boot mode code with a one-cycle done strobe. The code holds until the next reset. The 16-byte identifier area at FFC6h–FFD5h is never read.

Top module: `boot_sel`

## Requirements
- R1: While rst_ni is low, boot_done_o=0, boot_mode_o=2'b00 and mem_req_o=0.
- R2: The identification pattern is the bus value {sda_i,scl_i} sampled on the clock edges starting with the first edge after reset release. It must be 2'b01 for exactly HOLD_CYC samples, then 2'b10, 2'b01, 2'b10 for HOLD_CYC samples each. If all 4*HOLD_CYC samples match, mode 2'b01 (download) is reported and no memory request is ever made.
- R3: The first sample that breaks the pattern starts the signature read. This includes a wrong value, a phase held one sample short, or a phase held one sample long. No read starts earlier than that sample.
- R4: The signature is read as high byte from SIG_ADDR (FFD6h) first, then low byte from SIG_ADDR+1 (FFD7h). The address is held while a request waits for its acknowledge. No other address is requested.
- R5: If {high byte, low byte} equals A55Ah, the mode is 2'b10 (external application).
- R6: If {high byte, low byte} is any other value, the mode is 2'b11 (internal application).
- R7: If either read sees no acknowledge during ACK_TMO (16) request cycles, the mode is 2'b11. An acknowledge in the 16th request cycle is still accepted.
- R8: boot_done_o is high for exactly one cycle. boot_mode_o is non-zero from that cycle on and stays stable until reset. mem_req_o stays low after done.
- R9: Counting edges from reset release as 1, 2, ..., done is visible after these edges:
  - Download: edge 4*HOLD_CYC+1.
  - Break at edge F, with acknowledges in request cycles L1+1 and L2+1: edge F+3+L1+L2.
  - High-byte timeout: edge F+17.
  - Low-byte timeout: edge F+18+L1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Serial data line sample |
| scl_i | input | 1 | Serial clock line sample |
| mem_req_o | output | 1 | External byte read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_rdata_i | input | 8 | Read data, valid with ack |
| mem_ack_i | input | 1 | Read acknowledge |
| boot_mode_o | output | 2 | 01 download, 10 external, 11 internal |
| boot_done_o | output | 1 | One-cycle decision strobe |

## Verification
Every result is due at a fixed edge count after reset release, as given in R9. A break in the pattern registers at the edge that samples it. The sequencer reacts one edge later, and each acknowledged byte costs its wait plus one edge. The bench counts edges from reset, drives the lines and acknowledges half a cycle ahead, and notes the edge after which done first appears. That edge number and the mode are compared with values computed from the scenario's break point and acknowledge latencies. The bench sweeps all 256 values of each signature byte and every latency pair from 0 to 17.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  typedef enum logic [1:0] {
    BOOT_NONE = 2'b00,
    BOOT_DL   = 2'b01,
    BOOT_EXT  = 2'b10,
    BOOT_INT  = 2'b11
  } boot_mode_e;

  typedef enum logic [1:0] {
    SEQ_ID,
    SEQ_FETCH,
    SEQ_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    FET_IDLE,
    FET_HI,
    FET_LO
  } fet_st_e;
endpackage

// File: rtl/boot_id_detect.sv
module boot_id_detect #(
  parameter int HOLD   = 8,
  parameter int PHASES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic found_o,
  output logic fail_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] phase_q;
  logic [1:0]    line, expect_v;

  assign line     = {sda_i, scl_i};
  assign expect_v = phase_q[0] ? 2'b10 : 2'b01;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
      found_o <= 1'b0;
      fail_o  <= 1'b0;
    end else if (!found_o && !fail_o) begin
      if (line == expect_v) begin
        if (cnt_q == CW'(HOLD - 1)) begin
          cnt_q <= '0;
          if (phase_q == PW'(PHASES - 1)) found_o <= 1'b1;
          else                            phase_q <= phase_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        fail_o <= 1'b1;
      end
    end
  end

  // R3: one verdict only, and it sticks
  a_r3_single_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(found_o && fail_o));
  a_r3_verdict_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o || fail_o) |=> $stable({found_o, fail_o}));
endmodule

// File: rtl/boot_sig_fetch.sv
module boot_sig_fetch
  import boot_sel_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter int              TMO    = 16,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFFD6,
  parameter logic [15:0]     MAGIC  = 16'hA55A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [7:0]        rdata_i,
  input  logic              ack_i,
  output logic              fin_o,
  output logic              ext_o
);
  localparam int TW = (TMO > 1) ? $clog2(TMO) : 1;

  fet_st_e       st_q;
  logic [TW-1:0] wcnt_q;
  logic [7:0]    hi_q;
  logic          tmo;

  assign req_o  = (st_q != FET_IDLE);
  assign addr_o = (st_q == FET_LO) ? HI_ADDR + 1'b1 : HI_ADDR;
  assign tmo    = req_o && !ack_i && (wcnt_q == TW'(TMO - 1));
  assign fin_o  = ((st_q == FET_LO) && ack_i) || tmo;
  assign ext_o  = (st_q == FET_LO) && ack_i && ({hi_q, rdata_i} == MAGIC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FET_IDLE;
      wcnt_q <= '0;
      hi_q   <= '0;
    end else begin
      case (st_q)
        FET_IDLE: if (start_i) begin
          st_q   <= FET_HI;
          wcnt_q <= '0;
        end
        FET_HI: begin
          if (ack_i) begin
            hi_q   <= rdata_i;
            st_q   <= FET_LO;
            wcnt_q <= '0;
          end else if (tmo) st_q <= FET_IDLE;
          else              wcnt_q <= wcnt_q + 1'b1;
        end
        FET_LO: begin
          if (ack_i || tmo) st_q <= FET_IDLE;
          else              wcnt_q <= wcnt_q + 1'b1;
        end
        default: st_q <= FET_IDLE;
      endcase
    end
  end

  // R4: address held while a request waits
  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !tmo) |=> (req_o && $stable(addr_o)));
  // R4: low byte is only requested right after the high byte was acknowledged
  a_r4_hi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && addr_o == HI_ADDR && ack_i) |=> (req_o && addr_o == HI_ADDR + 1'b1));
endmodule

// File: rtl/boot_sel.sv
module boot_sel
  import boot_sel_pkg::*;
#(
  parameter int                HOLD_CYC  = 8,
  parameter int                ID_PHASES = 4,
  parameter int                ACK_TMO   = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SIG_ADDR  = 16'hFFD6,
  parameter logic [15:0]       SIG_MAGIC = 16'hA55A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [1:0]        boot_mode_o,
  output logic              boot_done_o
);
  seq_st_e    st_q;
  boot_mode_e mode_q;
  logic       done_q, id_found, id_fail, fet_start, fet_fin, fet_ext;

  boot_id_detect #(.HOLD(HOLD_CYC), .PHASES(ID_PHASES)) u_id (
    .clk_i, .rst_ni, .sda_i, .scl_i,
    .found_o (id_found),
    .fail_o  (id_fail)
  );

  assign fet_start = (st_q == SEQ_ID) && id_fail;

  boot_sig_fetch #(
    .ADDR_W(ADDR_W), .TMO(ACK_TMO), .HI_ADDR(SIG_ADDR), .MAGIC(SIG_MAGIC)
  ) u_fetch (
    .clk_i, .rst_ni,
    .start_i (fet_start),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .rdata_i (mem_rdata_i),
    .ack_i   (mem_ack_i),
    .fin_o   (fet_fin),
    .ext_o   (fet_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_ID;
      mode_q <= BOOT_NONE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SEQ_ID: begin
          if (id_found) begin
            mode_q <= BOOT_DL;
            done_q <= 1'b1;
            st_q   <= SEQ_DONE;
          end else if (id_fail) st_q <= SEQ_FETCH;
        end
        SEQ_FETCH: if (fet_fin) begin
          mode_q <= fet_ext ? BOOT_EXT : BOOT_INT;
          done_q <= 1'b1;
          st_q   <= SEQ_DONE;
        end
        default: st_q <= SEQ_DONE;
      endcase
    end
  end

  assign boot_mode_o = mode_q;
  assign boot_done_o = done_q;

  // R8
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> !boot_done_o);
  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_DONE) |=> ($stable(boot_mode_o) && !mem_req_o));
  a_r8_mode_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |-> (boot_mode_o != 2'b00));
  // R2, R3: no memory traffic while the pattern is still being checked
  a_r3_no_early_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_ID) |-> !mem_req_o);
endmodule

// File: tb/boot_sel_tb.sv
`timescale 1ns/1ps
module boot_sel_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sda = 1'b1, scl = 1'b1;
  logic        req, ack = 1'b0, done;
  logic [15:0] addr;
  logic [7:0]  rdata = 8'h00;
  logic [1:0]  mode;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  boot_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl),
    .mem_req_o(req), .mem_addr_o(addr), .mem_rdata_i(rdata), .mem_ack_i(ack),
    .boot_mode_o(mode), .boot_done_o(done)
  );

  // scenario
  int       id_len, l1, l2;
  logic [1:0] dev;
  logic [7:0] b_hi, b_lo;

  // observation
  int       cyc, done_edge, done_cnt, mcnt, n_ack;
  logic [15:0] last_addr, ack_a0, ack_a1;
  logic [1:0]  mode_at;
  bit       seen, any_req, late_bad;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic [1:0] line_at(int n);
    if (n <= id_len) return (((n - 1) / 8) % 2) ? 2'b10 : 2'b01;
    if (n == id_len + 1) return dev;
    return 2'b11;
  endfunction

  always @(negedge clk) begin
    logic [1:0] lv;
    int lat;
    lv = line_at(cyc + 1);
    {sda, scl} = lv;
    if (rst_n) begin
      if (req) any_req = 1;
      if (done) begin
        done_cnt++;
        if (!seen) begin seen = 1; done_edge = cyc; mode_at = mode; end
      end else if (seen && (mode !== mode_at || req)) late_bad = 1;
      if (!req) begin
        ack = 0; mcnt = 0; last_addr = 16'h0000;
      end else begin
        if (addr != last_addr) mcnt = 0;
        lat = (addr == 16'hFFD6) ? l1 : l2;
        ack = (mcnt == lat);
        rdata = (addr == 16'hFFD6) ? b_hi : (addr == 16'hFFD7) ? b_lo : 8'h00;
        if (ack) begin
          if (n_ack == 0) ack_a0 = addr; else ack_a1 = addr;
          n_ack++;
        end
        mcnt++;
        last_addr = addr;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ack = 0;
    seen = 0; any_req = 0; late_bad = 0; done_cnt = 0; done_edge = -1;
    n_ack = 0; mcnt = 0; ack_a0 = 0; ack_a1 = 0; last_addr = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(int idl, logic [1:0] dv, logic [7:0] h, logic [7:0] lo,
                     int a1, int a2, bit full);
    int f, exp_edge, exp_mode;
    id_len = idl; dev = dv; b_hi = h; b_lo = lo; l1 = a1; l2 = a2;
    do_reset();
    for (int i = 0; i < 90 && !seen; i++) @(negedge clk);
    for (int i = 0; i < 4; i++) @(negedge clk);
    if (idl >= 32) begin
      exp_edge = 33; exp_mode = 1;
    end else begin
      f = idl + 1;
      if (a1 >= 16)      begin exp_edge = f + 17;      exp_mode = 3; end
      else if (a2 >= 16) begin exp_edge = f + 18 + a1; exp_mode = 3; end
      else begin
        exp_edge = f + 3 + a1 + a2;
        exp_mode = ({h, lo} == 16'hA55A) ? 2 : 3;
      end
    end
    // R2 / R5 / R6 / R7 mode code
    check(mode_at == 2'(exp_mode),
          exp_mode == 1 ? "R2 mode" : exp_mode == 2 ? "R5 mode" : (a1 >= 16 || a2 >= 16) ? "R7 mode" : "R6 mode",
          mode_at, exp_mode);
    if (!full) return;
    check(done_edge == exp_edge, "R9 done edge", done_edge, exp_edge);
    check(done_cnt == 1 && !late_bad, "R8 pulse/hold", done_cnt, 1);
    if (idl >= 32) check(!any_req, "R2 no request", any_req, 0);
    else if (a1 < 16) check(ack_a0 == 16'hFFD6, "R4 first addr", ack_a0, 16'hFFD6);
    if (idl < 32 && a1 < 16 && a2 < 16)
      check(n_ack == 2 && ack_a1 == 16'hFFD7, "R4 second addr", ack_a1, 16'hFFD7);
  endtask

  initial begin
    // R1 reset state
    rst_n = 0; id_len = 0; dev = 2'b11; l1 = 0; l2 = 0;
    repeat (3) @(negedge clk);
    check(done == 0 && mode == 2'b00 && req == 0, "R1 reset", {done, mode, req}, 0);

    // R2 full pattern
    run(32, 2'b11, 8'hA5, 8'h5A, 0, 0, 1);
    // R3 breaks: idle bus, wrong value, short hold, long hold, late break
    run(0,  2'b11, 8'hA5, 8'h5A, 0, 0, 1);
    run(20, 2'b00, 8'hA5, 8'h5A, 1, 2, 1);
    run(7,  2'b10, 8'hA5, 8'h5A, 0, 0, 1);
    run(8,  2'b01, 8'hA5, 8'h5A, 3, 0, 1);
    run(31, 2'b01, 8'h12, 8'h34, 0, 5, 1);
    // R5/R6 sweep of each byte
    for (int v = 0; v < 256; v++) run(0, 2'b11, 8'(v), 8'h5A, 0, 0, v[3:0] == 0);
    for (int v = 0; v < 256; v++) run(0, 2'b11, 8'hA5, 8'(v), 0, 0, v[3:0] == 0);
    run(0, 2'b11, 8'h5A, 8'hA5, 0, 0, 1);  // R6 swapped bytes
    // R7 / R9 latency sweep incl. 15 (accepted) and 16+ (timeout)
    for (int a = 0; a < 18; a++)
      for (int b = 0; b < 18; b++) run(0, 2'b11, 8'hA5, 8'h5A, a, b, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule